// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target side of a two-wire serial bus in front of a 256-byte memory. It runs on a system clock and oversamples the bus clock and data lines. It detects start and stop conditions, receives the device select byte, the word address and the data bytes, and returns acknowledges on the open-drain data line. It supports single-byte writes, page writes, reads at the current address, random reads and sequential reads.

The memory itself sits in a neighbouring block. Reads use a combinational read port. Writes are held in a page buffer inside the engine. They are released to the memory as a burst of write strobes only after a stop condition closes the write. After that burst the engine stays busy for a fixed number of system clocks, the self-timed write cycle, and ignores the bus during that time. A master polls for the end of the cycle by sending the select byte until it is acknowledged.

Top module: `eeprom_bus_target`

## Requirements
- R1: A select byte, sent most significant bit first, is acknowledged when its upper four bits equal `CTRL_CODE` (default 4'b1010) and bits 3..1 equal `sel_i`. The engine acknowledges by holding SDA low for the whole ninth SCL clock. Bit 0 selects the direction: 1 means read.
- R2: A select byte that does not match is not acknowledged. The bytes that follow are not acknowledged either until the next start, and no write results from them.
- R3: In a write, the first byte after the select byte sets the word address. No byte reaches the memory before the stop condition. After the stop, every buffered byte is written to the memory exactly once.
- R4: During a page write the low `PAGE_W` (default 4) address bits advance after each data byte and wrap inside the page. When more bytes arrive than the page holds, a later byte replaces an earlier one at the same offset.
- R5: A start that arrives while a write is still open discards the buffered data, so nothing is written.
- R6: After the stop that commits a write, `busy_o` is high for the write burst plus `WR_CYCLES` clocks. During that time SDA is never driven and no select byte is acknowledged. After that time, select bytes are acknowledged again.
- R7: A read returns the byte at the internal address pointer, which then advances by one and wraps from 0xFF to 0x00. After a write the pointer is one past the last byte written, wrapped within the page.
- R8: A random read is a write that carries only the word address, followed by a repeated start and a read select byte. It returns the byte at that address.
- R9: While the master acknowledges each read byte, the engine sends the next byte. After a master no-acknowledge the engine releases SDA.
- R10: A master can recover a stalled bus with at most nine SCL clocks while SDA is released, followed by a start. The engine then accepts a select byte again.
- R11: Data is sent most significant bit first. The SDA drive changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sel_i | input | 3 | Strapped select bits |
| busy_o | output | 1 | Write burst or self-timed write cycle in progress |
| rd_addr_o | output | 8 | Memory read address (current pointer) |
| rd_data_i | input | 8 | Memory read data, combinational from rd_addr_o |
| wr_valid_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 8 | Memory write address |
| wr_data_o | output | 8 | Memory write data |

## Verification
The bench builds the engine with `FILT_LEN` = 2 and `WR_CYCLES` = 600. It drives one SCL quarter period per eight system clocks. With these values, a full poll consisting of a start and a select byte fits inside the busy window, and the window's end is reached quickly enough to test acknowledges on both sides of it. The default cycle count of 1.25 million would make that unreachable. The short filter leaves enough margin for the engine's SDA changes to settle well inside each SCL low phase. The same margin lets the bus recovery sequence form a clean start while the engine is still in the middle of a read byte.

// File: rtl/eeprom_bus_pkg.sv
package eeprom_bus_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_COMMIT, ST_BUSY
  } eng_state_e;
endpackage

// File: rtl/bus_line_filter.sv
module bus_line_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != line_o) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          line_o <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edge while SCL stays high
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/page_buf.sv
module page_buf #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [PAGE_W-1:0] push_off_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [PAGE_W-1:0] scan_i,
  output logic              any_o,
  output logic              scan_vld_o,
  output logic [DATA_W-1:0] scan_data_o
);
  localparam int unsigned DEPTH = 1 << PAGE_W;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i]  <= 1'b0;
        data_q[i] <= '0;
      end else if (clr_i) begin
        vld_q[i] <= 1'b0;
      end else if (push_i && push_off_i == PAGE_W'(i)) begin
        vld_q[i]  <= 1'b1;
        data_q[i] <= push_data_i;
      end
    end
  end

  assign any_o       = |vld_q;
  assign scan_vld_o  = vld_q[scan_i];
  assign scan_data_o = data_q[scan_i];
endmodule

// File: rtl/eeprom_bus_target.sv
module eeprom_bus_target
  import eeprom_bus_pkg::*;
#(
  parameter logic [3:0]  CTRL_CODE = 4'b1010,
  parameter int unsigned FILT_LEN  = 3,
  parameter int unsigned WR_CYCLES = 1250000,
  parameter int unsigned PAGE_W    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] sel_i,
  output logic       busy_o,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i,
  output logic       wr_valid_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  localparam int unsigned AW = 8;
  localparam int unsigned TW = $clog2(WR_CYCLES + 1);
  localparam logic [PAGE_W-1:0] SCAN_LAST = '1;

  logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;

  bus_line_filter #(.FILT_LEN(FILT_LEN)) i_scl_filt (
    .clk_i, .rst_ni, .line_i(scl_i), .line_o(scl_f));
  bus_line_filter #(.FILT_LEN(FILT_LEN)) i_sda_filt (
    .clk_i, .rst_ni, .line_i(sda_i), .line_o(sda_f));

  bus_cond_detect i_cond (
    .clk_i, .rst_ni, .scl_i(scl_f), .sda_i(sda_f),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det));

  eng_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sr_q, tx_q, ptr_q;
  logic              rd_q, mack_q, oe_q;
  logic [PAGE_W-1:0] scan_q;
  logic [TW-1:0]     tmr_q;

  logic locked, byte_end, dev_hit, commit_ok, buf_clr, push;
  logic buf_any, scan_vld;
  logic [7:0] scan_data;

  assign locked    = (state_q == ST_COMMIT) || (state_q == ST_BUSY);
  assign byte_end  = scl_fall && (cnt_q == 4'd8);
  assign dev_hit   = (sr_q[7:4] == CTRL_CODE) && (sr_q[3:1] == sel_i);
  assign commit_ok = ((state_q == ST_WDATA) || (state_q == ST_WDATA_ACK)) && buf_any;
  assign buf_clr   = (!locked && start_det) || (state_q == ST_COMMIT && scan_q == SCAN_LAST);
  assign push      = !locked && !start_det && !stop_det && state_q == ST_WDATA && byte_end;

  page_buf #(.PAGE_W(PAGE_W), .DATA_W(8)) i_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .push_i(push),
    .push_off_i(ptr_q[PAGE_W-1:0]), .push_data_i(sr_q),
    .scan_i(scan_q), .any_o(buf_any), .scan_vld_o(scan_vld),
    .scan_data_o(scan_data));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      scan_q  <= '0;
      tmr_q   <= '0;
    end else if (!locked && start_det) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (!locked && stop_det) begin
      state_q <= commit_ok ? ST_COMMIT : ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      scan_q  <= '0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sr_q  <= {sr_q[6:0], sda_f};
            cnt_q <= cnt_q + 4'd1;
          end
          if (byte_end) begin
            if (state_q == ST_DEV) begin
              if (dev_hit) begin
                oe_q    <= 1'b1;
                rd_q    <= sr_q[0];
                state_q <= ST_DEV_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_WADDR) begin
              ptr_q   <= sr_q;
              oe_q    <= 1'b1;
              state_q <= ST_WADDR_ACK;
            end else begin
              // offset wraps inside the page
              ptr_q   <= {ptr_q[AW-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
              oe_q    <= 1'b1;
              state_q <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rd_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[7];
              ptr_q   <= ptr_q + 8'd1;
              state_q <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_RACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              oe_q  <= ~tx_q[6];
              cnt_q <= cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_f;
          if (scl_fall) begin
            if (mack_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[7];
              ptr_q   <= ptr_q + 8'd1;
              cnt_q   <= '0;
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_COMMIT: begin
          scan_q <= scan_q + 1'b1;
          if (scan_q == SCAN_LAST) begin
            tmr_q   <= '0;
            state_q <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (tmr_q == TW'(WR_CYCLES - 1)) state_q <= ST_IDLE;
          else tmr_q <= tmr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o   = oe_q;
  assign busy_o     = locked;
  assign rd_addr_o  = ptr_q;
  assign wr_valid_o = (state_q == ST_COMMIT) && scan_vld;
  assign wr_addr_o  = {ptr_q[AW-1:PAGE_W], scan_q};
  assign wr_data_o  = scan_data;
endmodule

// File: rtl/eeprom_bus_chk.sv
module eeprom_bus_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe_o,
  input logic busy_o,
  input logic wr_valid_o
);
  p_oe_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe_o));

  p_quiet_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  p_wr_in_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> busy_o);

  p_busy_after_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_det));

  p_start_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && !busy_o) |=> !sda_oe_o);
endmodule

bind eeprom_bus_target eeprom_bus_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_f(scl_f), .start_det(start_det),
  .stop_det(stop_det), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
  .wr_valid_o(wr_valid_o));

// File: tb/test_eeprom_bus_target.sv
module test_eeprom_bus_target;
  localparam int Q  = 8;
  localparam int WR = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] sel = 3'b101;
  logic sda_oe, busy, wr_valid;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  logic [7:0] mdl [256];
  logic [7:0] wq [$];
  int mptr = 0;
  int n_chk = 0, n_fail = 0;
  bit commit_win = 1'b0;

  eeprom_bus_target #(.FILT_LEN(2), .WR_CYCLES(WR)) i_eeprom_bus_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .sel_i(sel), .busy_o(busy),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (wr_valid) begin
      mem[wr_addr] <= wr_data;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock: a memory write strobe only in a window the model opened (R3, R5)
  always @(negedge clk) begin
    if (rst_n && wr_valid) check(commit_win, "R3", "write strobe outside commit", 1, 0);
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic bit_x(input logic b, output logic s);
    sda_m = b; qwait(); scl_m = 1'b1; qwait();
    s = sda_line; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], s);
    bit_x(1'b1, s);
    ack = (s == 1'b0);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b, output logic ack_line);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, s);
      b[i] = s;
    end
    bit_x(give_ack ? 1'b0 : 1'b1, ack_line);
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, sel, rd};
  endfunction

  task automatic read_cur(input int n, input string req);
    bit ack;
    logic [7:0] b;
    logic al;
    bus_start();
    send_byte(dev(1'b1), ack);
    check(ack, "R1", "read select ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b, al);
      check(b == mdl[mptr], req, $sformatf("read byte (R11 order) at %0h", mptr), b, mdl[mptr]);
      mptr = (mptr + 1) % 256;
      if (i == n - 1) check(al == 1'b1, "R9", "released after master nack", al, 1);
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] addr, input int n, input string req);
    bit ack;
    bus_start();
    send_byte(dev(1'b0), ack);
    check(ack, "R8", "dummy write select ack", ack, 1);
    send_byte(addr, ack);
    check(ack, "R8", "dummy write address ack", ack, 1);
    mptr = addr;
    read_cur(n, req);
  endtask

  // writes wq at addr, polls during busy with a write to poll_addr
  task automatic do_write(input logic [7:0] addr, input logic [7:0] poll_addr);
    bit ack;
    logic [3:0] off;
    bus_start();
    send_byte(dev(1'b0), ack);
    check(ack, "R1", "write select ack", ack, 1);
    send_byte(addr, ack);
    check(ack, "R3", "word address ack", ack, 1);
    foreach (wq[i]) begin
      send_byte(wq[i], ack);
      check(ack, "R4", "data byte ack", ack, 1);
    end
    check(mem[addr] == mdl[addr], "R3", "memory untouched before stop", mem[addr], mdl[addr]);
    off = addr[3:0];
    foreach (wq[i]) begin
      mdl[{addr[7:4], off}] = wq[i];
      off = off + 4'd1;
    end
    mptr = {addr[7:4], off};
    commit_win = 1'b1;
    bus_stop();
    check(busy == 1'b1, "R6", "busy after stop", busy, 1);
    bus_start();
    send_byte(dev(1'b0), ack);
    check(!ack, "R6", "poll select during busy", ack, 0);
    send_byte(poll_addr, ack);
    send_byte(8'hE7, ack);
    check(!ack, "R6", "data during busy", ack, 0);
    bus_stop();
    repeat (WR + 40) @(negedge clk);
    check(busy == 1'b0, "R6", "busy ends", busy, 0);
    commit_win = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== mdl[i]) bad++;
      check(bad == 0, "R4", "memory matches model after commit", bad, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ack;
    logic s;
    logic [7:0] b;
    logic al;
    int nclk;
    bit got;
    for (int i = 0; i < 256; i++) mdl[i] = 8'(i) ^ 8'h5A;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sda_oe == 1'b0, "R6", "reset: SDA released", sda_oe, 0);
    check(busy == 1'b0, "R6", "reset: not busy", busy, 0);
    check(wr_valid == 1'b0, "R3", "reset: no write", wr_valid, 0);

    // R3 single byte write, then R8 random read back
    wq = {8'hA5};
    do_write(8'h10, 8'h80);
    rand_read(8'h10, 1, "R8");
    check(mem[8'h80] == mdl[8'h80], "R6", "write during busy ignored", mem[8'h80], mdl[8'h80]);

    // R4 page wrap: 2E,2F,20,21
    wq = {8'h11, 8'h22, 8'h33, 8'h44};
    do_write(8'h2E, 8'h81);
    // R4 overrun: 18 bytes into page 0x40
    wq = {};
    for (int k = 0; k < 18; k++) wq.push_back(8'(k * 7 + 3));
    do_write(8'h40, 8'h82);
    // R7 current address after write: next byte after 0x41 is 0x42
    read_cur(1, "R7");
    // R9 sequential read across a page
    rand_read(8'h20, 16, "R9");
    // R7 pointer wrap past 0xFF, then continues at 0x01
    rand_read(8'hFE, 3, "R7");
    read_cur(1, "R7");

    // R2 mismatched select bits and wrong control nibble
    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, ack);
    check(!ack, "R2", "wrong select bits", ack, 0);
    send_byte(8'h70, ack);
    check(!ack, "R2", "byte after mismatch", ack, 0);
    send_byte(8'h99, ack);
    bus_stop();
    bus_start();
    send_byte({4'b0110, sel, 1'b0}, ack);
    check(!ack, "R2", "wrong control nibble", ack, 0);
    bus_stop();
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R2", "no write cycle after mismatch", busy, 0);

    // R5 repeated start aborts an open write
    bus_start();
    send_byte(dev(1'b0), ack);
    send_byte(8'h60, ack);
    send_byte(8'h3C, ack);
    check(ack, "R5", "data acked before abort", ack, 1);
    for (int i = 0; i < 4; i++) bit_x(1'b0, s);
    bus_start();
    bus_stop();
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R5", "no commit after abort", busy, 0);
    rand_read(8'h60, 1, "R5");

    // R10 recovery from the middle of a read byte (mem[30] = 6A)
    bus_start();
    send_byte(dev(1'b0), ack);
    send_byte(8'h30, ack);
    bus_start();
    send_byte(dev(1'b1), ack);
    for (int i = 0; i < 3; i++) bit_x(1'b1, s);
    got = 1'b0;
    nclk = 0;
    for (int k = 0; k < 9; k++) begin
      sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
      if (sda_line) begin
        sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
        got = 1'b1;
        nclk = k + 1;
        break;
      end
      qwait(); scl_m = 1'b0; qwait();
    end
    check(got && nclk <= 9, "R10", "SDA free within nine clocks", nclk, 9);
    send_byte(dev(1'b1), ack);
    check(ack, "R10", "select after recovery", ack, 1);
    recv_byte(1'b0, b, al);
    check(b == mdl[8'h31], "R10", "read after recovery", b, mdl[8'h31]);
    bus_stop();

    repeat (20) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule